// File: doc/BRIEF.md
# Sub-word register write-combining bridge

This bridge connects a host bus that issues 8-, 16- and 32-bit register accesses to a register file that only accepts aligned 32-bit words. For a sub-word read, the bridge fetches the containing word and returns the addressed lane, zero-extended. For a sub-word write, it reads the word, replaces the addressed lane and writes the word back.

The block-size, block-count and transfer-mode halfwords are handled differently. The bridge holds them in two shadow words and does not pass them on right away. When the command halfword is written, the bridge issues them as at most two back-to-back 32-bit writes: first the block word, then the transfer-mode/command word. The register file therefore never sees successive partial updates of those words.

When the configured card clock is slow, every downstream write is followed by a stall. Its length is measured in microsecond ticks. During the stall the bridge accepts no new access.

Top module: `sw_reg_bridge`

## Requirements
- R1: After reset, `up_ready` is high, no downstream request is made and both shadow flags are clear, so a 16-bit read of block size (byte address 0x04) is served from the register file.
- R2: A downstream access always uses the byte address with bits [1:0] cleared. A sub-word read returns the lane at bit offset 8×addr[1:0], zero-extended. A read that goes downstream completes with `up_rvalid` in the third cycle after acceptance (`up_size` 1 = byte, 2 = halfword, 4 = word).
- R3: A byte write reads the downstream word, replaces only the addressed byte and writes the word back once. It is never shadowed.
- R4: A 16-bit write to any address other than 0x04, 0x06, 0x0C and 0x0E is a read-modify-write of one halfword lane.
- R5: A 16-bit write to 0x04 or 0x06 merges into the block shadow word, sets the block flag and makes no downstream write. The merge base is the shadow word if the flag is set, and otherwise a downstream read.
- R6: A 16-bit write to transfer mode (0x0C) merges into the command shadow word over a downstream read, sets the command flag and makes no downstream write.
- R7: A 16-bit write to command (0x0E) with the block flag set first writes the block shadow word to address 0x04, then the command word. Both flags are clear afterwards.
- R8: The command halfword is merged over the command shadow word without a downstream read. It is written to address 0x0C as a single 32-bit write.
- R9: A 16-bit read of 0x0C while the command flag is set, or of 0x04/0x06 while the block flag is set, returns the shadow lane in the first cycle after acceptance and issues no downstream read.
- R10: 32-bit reads and writes pass straight through. They neither read nor change the shadow words or flags.
- R11: After each downstream write, if `card_clk_hz` is at most 400000, `up_ready` stays low for ceil(4000000/`card_clk_hz`) `us_tick` pulses, or for 10 pulses if it is 0. Above 400000 there is no stall. Shadow-only writes never stall.
- R12: `up_ready` is low whenever the bridge is busy, and a downstream request is never made while `up_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| up_valid | input | 1 | Host access request |
| up_ready | output | 1 | Bridge can accept an access |
| up_write | input | 1 | 1 = write, 0 = read |
| up_size | input | 3 | Access size in bytes: 1, 2 or 4 |
| up_addr | input | ADDR_W | Byte address |
| up_wdata | input | 32 | Write data, right-aligned |
| up_rvalid | output | 1 | Read data valid (one-cycle pulse) |
| up_rdata | output | 32 | Read data, right-aligned and zero-extended |
| dn_req | output | 1 | Downstream access strobe |
| dn_we | output | 1 | Downstream write enable |
| dn_addr | output | ADDR_W | Downstream word-aligned byte address |
| dn_wdata | output | 32 | Downstream write word |
| dn_rdata | input | 32 | Downstream read word, valid the cycle after a read strobe |
| card_clk_hz | input | 32 | Configured card clock in Hz |
| us_tick | input | 1 | One-cycle pulse per microsecond |

## Verification
Timing is counted in cycles after the edge at which the access is accepted:

| Result | Due |
|---|---|
| Downstream read result | `up_rvalid`, third cycle |
| Shadow read result | first cycle |
| Downstream write for a sub-word read-modify-write | third cycle |

The bench samples at the falling edge exactly that many cycles after acceptance. It does not poll for the result.

Stall lengths are checked by counting falling edges with `up_ready` low, with `us_tick` held high. The expected counts are:

| Access | Ready-low cycles |
|---|---|
| Read-modify-write | 3 + N |
| Command with block flush | 2 + 2N |

The downstream model logs every write, so the number, order, addresses and data of writes are checked after each access completes.

// File: rtl/sw_bridge_pkg.sv
package sw_bridge_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD,
        ST_RDW,
        ST_WRBLK,
        ST_WR,
        ST_HOLD,
        ST_RESP
    } br_state_e;

    typedef enum logic [1:0] {
        OP_READ,
        OP_RMW,
        OP_SHBLK,
        OP_SHXFER
    } br_op_e;

    // Lane mask for a byte count: 1 -> byte, 2 -> halfword, anything else -> word
    function automatic logic [WORD_W-1:0] lane_mask(input logic [2:0] size);
        case (size)
            3'd1:    lane_mask = WORD_W'(32'h0000_00FF);
            3'd2:    lane_mask = WORD_W'(32'h0000_FFFF);
            default: lane_mask = '1;
        endcase
    endfunction

    function automatic logic [4:0] lane_shift(input logic [1:0] lane, input logic [2:0] size);
        lane_shift = (size == 3'd1 || size == 3'd2) ? {lane, 3'b000} : 5'd0;
    endfunction

endpackage

// File: rtl/sw_lane_pick.sv
module sw_lane_pick
    import sw_bridge_pkg::*;
(
    input  logic [WORD_W-1:0] word_i,
    input  logic [1:0]        lane_i,
    input  logic [2:0]        size_i,
    output logic [WORD_W-1:0] data_o
);
    logic [4:0] sh;

    always_comb begin
        sh     = lane_shift(lane_i, size_i);
        data_o = (word_i >> sh) & lane_mask(size_i);
    end
endmodule

// File: rtl/sw_lane_merge.sv
module sw_lane_merge
    import sw_bridge_pkg::*;
(
    input  logic [WORD_W-1:0] base_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [1:0]        lane_i,
    input  logic [2:0]        size_i,
    output logic [WORD_W-1:0] word_o
);
    logic [4:0]        sh;
    logic [WORD_W-1:0] msk;

    always_comb begin
        sh     = lane_shift(lane_i, size_i);
        msk    = lane_mask(size_i);
        word_o = (base_i & ~(msk << sh)) | ((wdata_i & msk) << sh);
    end
endmodule

// File: rtl/sw_holdoff_len.sv
module sw_holdoff_len #(
    parameter int unsigned SLOW_HZ      = 400000,
    parameter int unsigned HOLD_NUM     = 4000000,
    parameter int unsigned ZERO_HOLD_US = 10,
    parameter int unsigned CNT_W        = 32
) (
    input  logic [31:0]      clk_hz_i,
    output logic             slow_o,
    output logic [CNT_W-1:0] len_o
);
    logic [31:0] divisor;
    logic [31:0] quot;

    always_comb begin
        slow_o  = (clk_hz_i <= 32'(SLOW_HZ));
        divisor = (clk_hz_i == 32'd0) ? 32'd1 : clk_hz_i;
        quot    = (32'(HOLD_NUM) + divisor - 32'd1) / divisor;
        len_o   = (clk_hz_i == 32'd0) ? CNT_W'(ZERO_HOLD_US) : CNT_W'(quot);
    end
endmodule

// File: rtl/sw_reg_bridge.sv
module sw_reg_bridge
    import sw_bridge_pkg::*;
#(
    parameter int unsigned        ADDR_W       = 8,
    parameter logic [ADDR_W-1:0]  BLKSZ_ADDR   = ADDR_W'(8'h04),
    parameter logic [ADDR_W-1:0]  BLKCNT_ADDR  = ADDR_W'(8'h06),
    parameter logic [ADDR_W-1:0]  XFER_ADDR    = ADDR_W'(8'h0C),
    parameter logic [ADDR_W-1:0]  CMD_ADDR     = ADDR_W'(8'h0E),
    parameter int unsigned        SLOW_HZ      = 400000,
    parameter int unsigned        HOLD_NUM     = 4000000,
    parameter int unsigned        ZERO_HOLD_US = 10,
    parameter int unsigned        CNT_W        = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_valid,
    output logic              up_ready,
    input  logic              up_write,
    input  logic [2:0]        up_size,
    input  logic [ADDR_W-1:0] up_addr,
    input  logic [WORD_W-1:0] up_wdata,
    output logic              up_rvalid,
    output logic [WORD_W-1:0] up_rdata,
    output logic              dn_req,
    output logic              dn_we,
    output logic [ADDR_W-1:0] dn_addr,
    output logic [WORD_W-1:0] dn_wdata,
    input  logic [WORD_W-1:0] dn_rdata,
    input  logic [31:0]       card_clk_hz,
    input  logic              us_tick
);
    localparam logic [ADDR_W-1:0] BLK_WORD_ADDR = {BLKSZ_ADDR[ADDR_W-1:2], 2'b00};

    typedef struct packed {
        br_state_e         st;
        br_op_e            op;
        logic [ADDR_W-1:0] addr;
        logic [2:0]        size;
        logic [WORD_W-1:0] wdata;
        logic [WORD_W-1:0] word;
        logic [WORD_W-1:0] rdata;
        logic [WORD_W-1:0] blk_sh;
        logic [WORD_W-1:0] cmd_sh;
        logic              blk_f;
        logic              cmd_f;
        logic              pend;
        logic [CNT_W-1:0]  cnt;
    } br_regs_t;

    br_regs_t r_d, r_q;

    logic              in_rdw;
    logic              up_is_blk, up_is_xfer, up_is_cmd;
    logic [WORD_W-1:0] pick_word, pick_out;
    logic [WORD_W-1:0] merge_base, merge_wdata, merge_out;
    logic [1:0]        sel_lane;
    logic [2:0]        sel_size;
    logic              slow;
    logic [CNT_W-1:0]  hold_len;

    // Decode of the halfword registers that get special handling
    always_comb begin
        up_is_blk  = (up_size == 3'd2) && ((up_addr == BLKSZ_ADDR) || (up_addr == BLKCNT_ADDR));
        up_is_xfer = (up_size == 3'd2) && (up_addr == XFER_ADDR);
        up_is_cmd  = (up_size == 3'd2) && (up_addr == CMD_ADDR);
        in_rdw     = (r_q.st == ST_RDW);
        sel_lane   = in_rdw ? r_q.addr[1:0] : up_addr[1:0];
        sel_size   = in_rdw ? r_q.size : up_size;
        pick_word  = in_rdw ? dn_rdata : (up_is_xfer ? r_q.cmd_sh : r_q.blk_sh);
        merge_base = in_rdw ? dn_rdata : (up_is_cmd ? r_q.cmd_sh : r_q.blk_sh);
        merge_wdata = in_rdw ? r_q.wdata : up_wdata;
    end

    sw_lane_pick u_pick (
        .word_i (pick_word),
        .lane_i (sel_lane),
        .size_i (sel_size),
        .data_o (pick_out)
    );

    sw_lane_merge u_merge (
        .base_i  (merge_base),
        .wdata_i (merge_wdata),
        .lane_i  (sel_lane),
        .size_i  (sel_size),
        .word_o  (merge_out)
    );

    sw_holdoff_len #(
        .SLOW_HZ      (SLOW_HZ),
        .HOLD_NUM     (HOLD_NUM),
        .ZERO_HOLD_US (ZERO_HOLD_US),
        .CNT_W        (CNT_W)
    ) u_hold (
        .clk_hz_i (card_clk_hz),
        .slow_o   (slow),
        .len_o    (hold_len)
    );

    // Next-state computation
    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (up_valid) begin
                    r_d.addr  = up_addr;
                    r_d.size  = up_size;
                    r_d.wdata = up_wdata;
                    if (!up_write) begin
                        if ((up_is_xfer && r_q.cmd_f) || (up_is_blk && r_q.blk_f)) begin
                            r_d.rdata = pick_out;
                            r_d.st    = ST_RESP;
                        end else begin
                            r_d.op = OP_READ;
                            r_d.st = ST_RD;
                        end
                    end else if (up_size != 3'd1 && up_size != 3'd2) begin
                        r_d.word = up_wdata;
                        r_d.st   = ST_WR;
                    end else if (up_is_cmd) begin
                        r_d.word  = merge_out;
                        r_d.cmd_f = 1'b0;
                        r_d.st    = r_q.blk_f ? ST_WRBLK : ST_WR;
                    end else if (up_is_blk && r_q.blk_f) begin
                        r_d.blk_sh = merge_out;
                    end else begin
                        r_d.op = up_is_blk ? OP_SHBLK : (up_is_xfer ? OP_SHXFER : OP_RMW);
                        r_d.st = ST_RD;
                    end
                end
            end
            ST_RD: r_d.st = ST_RDW;
            ST_RDW: begin
                unique case (r_q.op)
                    OP_READ: begin
                        r_d.rdata = pick_out;
                        r_d.st    = ST_RESP;
                    end
                    OP_RMW: begin
                        r_d.word = merge_out;
                        r_d.st   = ST_WR;
                    end
                    OP_SHBLK: begin
                        r_d.blk_sh = merge_out;
                        r_d.blk_f  = 1'b1;
                        r_d.st     = ST_IDLE;
                    end
                    default: begin
                        r_d.cmd_sh = merge_out;
                        r_d.cmd_f  = 1'b1;
                        r_d.st     = ST_IDLE;
                    end
                endcase
            end
            ST_WRBLK: begin
                r_d.blk_f = 1'b0;
                r_d.pend  = 1'b1;
                r_d.cnt   = hold_len;
                r_d.st    = slow ? ST_HOLD : ST_WR;
            end
            ST_WR: begin
                r_d.pend = 1'b0;
                r_d.cnt  = hold_len;
                r_d.st   = slow ? ST_HOLD : ST_IDLE;
            end
            ST_HOLD: begin
                if (us_tick) begin
                    if (r_q.cnt <= CNT_W'(1)) begin
                        r_d.st = r_q.pend ? ST_WR : ST_IDLE;
                    end else begin
                        r_d.cnt = r_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, op: OP_READ, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    // Port drive
    always_comb begin
        up_ready  = (r_q.st == ST_IDLE);
        up_rvalid = (r_q.st == ST_RESP);
        up_rdata  = r_q.rdata;
        dn_req    = (r_q.st == ST_RD) || (r_q.st == ST_WR) || (r_q.st == ST_WRBLK);
        dn_we     = (r_q.st == ST_WR) || (r_q.st == ST_WRBLK);
        dn_addr   = (r_q.st == ST_WRBLK) ? BLK_WORD_ADDR : {r_q.addr[ADDR_W-1:2], 2'b00};
        dn_wdata  = (r_q.st == ST_WRBLK) ? r_q.blk_sh : r_q.word;
    end
endmodule

// File: rtl/sw_reg_bridge_chk.sv
module sw_reg_bridge_chk #(
    parameter int unsigned       ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] BLKSZ_ADDR  = ADDR_W'(8'h04),
    parameter logic [ADDR_W-1:0] BLKCNT_ADDR = ADDR_W'(8'h06),
    parameter logic [ADDR_W-1:0] XFER_ADDR   = ADDR_W'(8'h0C),
    parameter int unsigned       SLOW_HZ     = 400000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              up_valid,
    input logic              up_ready,
    input logic              up_write,
    input logic [2:0]        up_size,
    input logic [ADDR_W-1:0] up_addr,
    input logic              up_rvalid,
    input logic              dn_req,
    input logic              dn_we,
    input logic [ADDR_W-1:0] dn_addr,
    input logic [31:0]       card_clk_hz
);
    logic acc_blk_wr, acc_xfer_wr;
    assign acc_blk_wr  = up_valid && up_ready && up_write && (up_size == 3'd2) &&
                         ((up_addr == BLKSZ_ADDR) || (up_addr == BLKCNT_ADDR));
    assign acc_xfer_wr = up_valid && up_ready && up_write && (up_size == 3'd2) &&
                         (up_addr == XFER_ADDR);

    // R12
    ready_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_ready |-> !dn_req);

    // R2
    dn_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_req |-> (dn_addr[1:0] == 2'b00));

    // R12
    we_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dn_we |-> dn_req);

    // R9
    rvalid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        up_rvalid |=> !up_rvalid);

    // R5
    blk_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_blk_wr |=> !(dn_req && dn_we));

    // R6
    xfer_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_xfer_wr |=> !(dn_req && dn_we));

    // R11
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_req && dn_we && (card_clk_hz <= 32'(SLOW_HZ))) |=> !up_ready);
endmodule

bind sw_reg_bridge sw_reg_bridge_chk #(
    .ADDR_W      (ADDR_W),
    .BLKSZ_ADDR  (BLKSZ_ADDR),
    .BLKCNT_ADDR (BLKCNT_ADDR),
    .XFER_ADDR   (XFER_ADDR),
    .SLOW_HZ     (SLOW_HZ)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .up_valid    (up_valid),
    .up_ready    (up_ready),
    .up_write    (up_write),
    .up_size     (up_size),
    .up_addr     (up_addr),
    .up_rvalid   (up_rvalid),
    .dn_req      (dn_req),
    .dn_we       (dn_we),
    .dn_addr     (dn_addr),
    .card_clk_hz (card_clk_hz)
);

// File: tb/sw_reg_bridge_bench.sv
module sw_reg_bridge_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        up_valid = 1'b0;
    logic        up_ready;
    logic        up_write = 1'b0;
    logic [2:0]  up_size = 3'd4;
    logic [7:0]  up_addr = 8'h00;
    logic [31:0] up_wdata = 32'h0;
    logic        up_rvalid;
    logic [31:0] up_rdata;
    logic        dn_req, dn_we;
    logic [7:0]  dn_addr;
    logic [31:0] dn_wdata;
    logic [31:0] dn_rdata = 32'h0;
    logic [31:0] card_clk_hz = 32'd50_000_000;
    logic        us_tick = 1'b1;

    always #4 clk = ~clk;

    sw_reg_bridge u_sw_reg_bridge (
        .clk (clk), .rst_n (rst_n),
        .up_valid (up_valid), .up_ready (up_ready), .up_write (up_write),
        .up_size (up_size), .up_addr (up_addr), .up_wdata (up_wdata),
        .up_rvalid (up_rvalid), .up_rdata (up_rdata),
        .dn_req (dn_req), .dn_we (dn_we), .dn_addr (dn_addr),
        .dn_wdata (dn_wdata), .dn_rdata (dn_rdata),
        .card_clk_hz (card_clk_hz), .us_tick (us_tick)
    );

    // Downstream register file model, sampled away from the active edge
    logic [31:0] mem [64];
    logic [7:0]  wlog_addr [16];
    logic [31:0] wlog_data [16];
    int          wcnt = 0;
    int          poke_seq = 0, poke_done = 0;
    int          poke_idx = 0;
    logic [31:0] poke_val = 32'h0;
    int          n_tests = 0, n_fail = 0, cyc = 0;
    bit          finished = 1'b0;

    always @(negedge clk) begin
        if (poke_seq != poke_done) begin
            mem[poke_idx] <= poke_val;
            poke_done     <= poke_seq;
        end
        if (dn_req && !dn_we) dn_rdata <= mem[dn_addr[7:2]];
        if (dn_req && dn_we) begin
            mem[dn_addr[7:2]]  <= dn_wdata;
            wlog_addr[wcnt%16] <= dn_addr;
            wlog_data[wcnt%16] <= dn_wdata;
            wcnt               <= wcnt + 1;
        end
    end

    // Watchdog
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !finished) begin
            $display("FAIL watchdog: actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] val);
        poke_idx = idx;
        poke_val = val;
        poke_seq++;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic issue(input logic wr, input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        int g = 0;
        while (!up_ready && g < 200000) begin @(negedge clk); g++; end
        up_valid = 1'b1; up_write = wr; up_addr = a; up_size = sz; up_wdata = d;
        @(negedge clk);
        up_valid = 1'b0;
    endtask

    task automatic settle;
        int g = 0;
        while (!up_ready && g < 200000) begin @(negedge clk); g++; end
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
        issue(1'b1, a, sz, d);
        settle();
    endtask

    task automatic rd(input string req, input logic [7:0] a, input logic [2:0] sz, input int lat, input logic [31:0] exp);
        issue(1'b0, a, sz, 32'h0);
        repeat (lat - 1) @(negedge clk);
        chk(req, "rvalid due", {31'h0, up_rvalid}, 32'h1);
        chk(req, "read data", up_rdata, exp);
        settle();
    endtask

    task automatic measure(input string req, input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d, input int exp);
        int low = 0;
        issue(1'b1, a, sz, d);
        while (!up_ready && low < 200000) begin low++; @(negedge clk); end
        chk(req, "ready-low cycles", 32'(low), 32'(exp));
        settle();
    endtask

    task automatic t_reset;
        chk("R1", "ready after reset", {31'h0, up_ready}, 32'h1);
        chk("R1", "no dn request", {31'h0, dn_req}, 32'h0);
        chk("R1", "no rvalid", {31'h0, up_rvalid}, 32'h0);
        rd("R1", 8'h04, 3'd2, 3, 32'h0000_BBBB);
    endtask

    task automatic t_subword_read;
        rd("R2", 8'h11, 3'd1, 3, 32'h0000_00C3);
        rd("R2", 8'h13, 3'd1, 3, 32'h0000_00A1);
        rd("R2", 8'h12, 3'd2, 3, 32'h0000_A1B2);
        rd("R10", 8'h10, 3'd4, 3, 32'hA1B2_C3D4);
    endtask

    task automatic t_byte_write;
        int w0 = wcnt;
        wr(8'h21, 3'd1, 32'h55);
        chk("R3", "write count", 32'(wcnt - w0), 32'd1);
        chk("R3", "write addr", {24'h0, wlog_addr[w0%16]}, 32'h20);
        chk("R3", "write data", wlog_data[w0%16], 32'h1122_5544);
    endtask

    task automatic t_half_write;
        int w0 = wcnt;
        wr(8'h2A, 3'd2, 32'hBEEF);
        chk("R4", "write count", 32'(wcnt - w0), 32'd1);
        chk("R4", "write addr", {24'h0, wlog_addr[w0%16]}, 32'h28);
        chk("R4", "write data", wlog_data[w0%16], 32'hBEEF_FFFF);
    endtask

    task automatic t_block_shadow;
        int w0 = wcnt;
        wr(8'h04, 3'd2, 32'h1234);
        chk("R5", "no write on block size", 32'(wcnt - w0), 32'd0);
        poke(1, 32'hCCCC_DDDD);
        wr(8'h06, 3'd2, 32'h5678);
        chk("R5", "no write on block count", 32'(wcnt - w0), 32'd0);
        rd("R9", 8'h06, 3'd2, 1, 32'h0000_5678);
        rd("R9", 8'h04, 3'd2, 1, 32'h0000_1234);
        rd("R10", 8'h04, 3'd4, 3, 32'hCCCC_DDDD);
    endtask

    task automatic t_xfer_shadow;
        int w0 = wcnt;
        wr(8'h0C, 3'd2, 32'h0033);
        chk("R6", "no write on transfer mode", 32'(wcnt - w0), 32'd0);
        rd("R9", 8'h0C, 3'd2, 1, 32'h0000_0033);
        poke(3, 32'h7777_6666);
    endtask

    task automatic t_command_flush;
        int w0 = wcnt;
        wr(8'h0E, 3'd2, 32'h1A1B);
        chk("R7", "flush write count", 32'(wcnt - w0), 32'd2);
        chk("R7", "block word addr", {24'h0, wlog_addr[w0%16]}, 32'h04);
        chk("R7", "block word data", wlog_data[w0%16], 32'h5678_1234);
        chk("R8", "command addr", {24'h0, wlog_addr[(w0+1)%16]}, 32'h0C);
        chk("R8", "command data", wlog_data[(w0+1)%16], 32'h1A1B_0033);
        rd("R7", 8'h06, 3'd2, 3, 32'h0000_5678);
        rd("R7", 8'h0C, 3'd2, 3, 32'h0000_0033);
        w0 = wcnt;
        wr(8'h0E, 3'd2, 32'h0042);
        chk("R8", "single command write", 32'(wcnt - w0), 32'd1);
        chk("R8", "command base from shadow", wlog_data[w0%16], 32'h0042_0033);
    endtask

    task automatic t_word_passthru;
        int w0;
        wr(8'h04, 3'd2, 32'h1111);
        w0 = wcnt;
        wr(8'h04, 3'd4, 32'hDEAD_BEEF);
        chk("R10", "word write count", 32'(wcnt - w0), 32'd1);
        chk("R10", "word write data", wlog_data[w0%16], 32'hDEAD_BEEF);
        rd("R10", 8'h04, 3'd2, 1, 32'h0000_1111);
        rd("R10", 8'h06, 3'd2, 1, 32'h0000_5678);
        w0 = wcnt;
        wr(8'h0E, 3'd2, 32'h0001);
        chk("R10", "shadow survives word write", wlog_data[w0%16], 32'h5678_1111);
        chk("R7", "command after flush", wlog_data[(w0+1)%16], 32'h0001_0033);
    endtask

    task automatic t_holdoff;
        card_clk_hz = 32'd300000;
        measure("R11", 8'h20, 3'd1, 32'h01, 17);
        card_clk_hz = 32'd0;
        measure("R11", 8'h20, 3'd1, 32'h02, 13);
        card_clk_hz = 32'd400000;
        measure("R11", 8'h20, 3'd1, 32'h03, 13);
        card_clk_hz = 32'd400001;
        measure("R11", 8'h20, 3'd1, 32'h04, 3);
        card_clk_hz = 32'd200000;
        measure("R11", 8'h04, 3'd2, 32'h0AAA, 2);
        measure("R11", 8'h0E, 3'd2, 32'h0BBB, 42);
        measure("R12", 8'h06, 3'd2, 32'h0CCC, 2);
        measure("R12", 8'h06, 3'd2, 32'h0DDD, 0);
        card_clk_hz = 32'd50_000_000;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        poke(1, 32'hAAAA_BBBB);
        poke(3, 32'h9999_0000);
        poke(4, 32'hA1B2_C3D4);
        poke(8, 32'h1122_3344);
        poke(10, 32'h0000_FFFF);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_subword_read();
        t_byte_write();
        t_half_write();
        t_block_shadow();
        t_xfer_shadow();
        t_command_flush();
        t_word_passthru();
        t_holdoff();
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule